// File: doc/BRIEF.md
# UART Interrupt Source, Mask and Pending Controller

This block gathers the four interrupt causes of one UART channel (receive, error, transmit and modem), holds them in a sticky source register, and filters them through a mask. The result is a pending vector and one level interrupt line. Event strobes come from the receive, error, transmit and modem logic next to it. Software clears sources and sets the mask through a small write port. A combinational read port returns the pending, source and mask vectors and the transmitter status bits.

The block also works out the transmit-FIFO trigger condition. A 3-bit threshold selector is scaled by a multiplier that depends on the channel number, which is a build parameter. While the FIFO is enabled and the transmit FIFO fill count is at or below that level, the transmit source is raised on every cycle. A small transmitter status register tracks a byte from the moment it is accepted until it has been sent. Completion also raises the transmit source.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Source bit positions are fixed: bit 0 receive, bit 1 error, bit 2 transmit, bit 3 modem. A one-cycle strobe on an event input sets its bit at the next clock edge, and the bit stays set until it is cleared.
- R2: The pending vector equals source AND NOT mask. `irq_o` is high in exactly the cycles where some pending bit is set.
- R3: A write to register select 0 (pending) clears each source bit, and so each pending bit, where the write data holds a one. Bits written with zero are unchanged.
- R4: A write to register select 1 (source) clears the source bits where the write data holds a one. Other bits are unchanged.
- R5: A write to register select 2 (mask) replaces the whole mask. The read port and `irq_o` reflect the new mask from the cycle after the write edge.
- R6: While `fifo_en_i` is high and `tx_cnt_i` is less than or equal to the trigger level, the transmit source bit is set at the next edge. While `fifo_en_i` is low, the trigger never sets it.
- R7: The trigger level is `tx_trig_sel_i` times a channel multiplier: 32 for channel 0, 8 for channels 1 and 4, 2 for channels 2 and 3, and 0 for any other channel.
- R8: Register select 3 reads the transmitter status: bit 2 is transmitter empty, bit 1 is buffer empty, bits 0 and 3 read 0. Its reset value is 0x6. `tx_start_i` clears bits 2 and 1. `tx_done_i` sets them again and sets the transmit source. If both strobes come in the same cycle, `tx_done_i` wins.
- R9: If a set strobe and a clearing write hit the same source bit in the same cycle, the bit ends up set.
- R10: After reset the source and mask are zero, `irq_o` is low and the read port returns 0 for selects 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_evt_i | input | 1 | Receive event strobe |
| err_evt_i | input | 1 | Error event strobe |
| tx_evt_i | input | 1 | Transmit event strobe |
| modem_evt_i | input | 1 | Modem event strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Write register select (0 pending, 1 source, 2 mask) |
| wr_data_i | input | 4 | Write data, one bit per source |
| rd_addr_i | input | 2 | Read register select (0 pending, 1 source, 2 mask, 3 status) |
| rd_data_o | output | 4 | Combinational read data |
| fifo_en_i | input | 1 | FIFO mode enabled |
| tx_trig_sel_i | input | 3 | Transmit trigger threshold selector |
| tx_cnt_i | input | CNT_W | Transmit FIFO fill count |
| tx_start_i | input | 1 | A byte was accepted for sending |
| tx_done_i | input | 1 | The byte has been sent |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check the pending/interrupt relation, the sticky set and write-one-to-clear behaviour, set-over-clear priority, the one-cycle mask update, the trigger threshold against an independently scaled level, and the status transitions. Only the bench scenarios show the reset values, the exact boundary of the scaled threshold at its largest setting, clears that leave the bits written with zero untouched, and long mixed sequences. In those sequences a stale bit would only show up as a wrong read value several cycles later.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned SRC_RX = 0;
  localparam int unsigned SRC_ERR = 1;
  localparam int unsigned SRC_TX = 2;
  localparam int unsigned SRC_MODEM = 3;
  localparam int unsigned TRIG_W = 3;

  typedef enum logic [1:0] {
    REG_PEND = 2'd0,
    REG_SRC  = 2'd1,
    REG_MASK = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  function automatic int unsigned trig_scale(input int unsigned ch);
    case (ch)
      0:       return 32;
      1, 4:    return 8;
      2, 3:    return 2;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_trigger.sv
module uart_tx_trigger
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL = 1,
  parameter int unsigned CNT_W   = 8
) (
  input  logic              fifo_en_i,
  input  logic [TRIG_W-1:0] sel_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              hit_o
);
  localparam int unsigned SCALE = trig_scale(CHANNEL);
  localparam int unsigned LVL_W = CNT_W + 7;

  generate
    if (SCALE == 0) begin : g_zero
      logic unused_sel;
      assign unused_sel = ^sel_i;
      assign hit_o = fifo_en_i && (cnt_i == '0);
    end else begin : g_scaled
      logic [LVL_W-1:0] level;
      assign level = LVL_W'(sel_i) * LVL_W'(SCALE);
      assign hit_o = fifo_en_i && (LVL_W'(cnt_i) <= level);
    end
  endgenerate
endmodule

// File: rtl/uart_irq_src_regs.sv
module uart_irq_src_regs
  import uart_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_d_i,
  output logic [NUM_SRC-1:0] src_o,
  output logic [NUM_SRC-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= '0;
      mask_o <= '0;
    end else begin
      // set has priority so no event is lost
      src_o <= (src_o & ~clr_i) | set_i;
      if (mask_we_i) mask_o <= mask_d_i;
    end
  end
endmodule

// File: rtl/uart_tx_status.sv
module uart_tx_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic done_i,
  output logic xmit_empty_o,
  output logic buf_empty_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xmit_empty_o <= 1'b1;
      buf_empty_o  <= 1'b1;
    end else if (done_i) begin
      xmit_empty_o <= 1'b1;
      buf_empty_o  <= 1'b1;
    end else if (start_i) begin
      xmit_empty_o <= 1'b0;
      buf_empty_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int unsigned CHANNEL = 1,
  parameter int unsigned CNT_W   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_evt_i,
  input  logic               err_evt_i,
  input  logic               tx_evt_i,
  input  logic               modem_evt_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  input  logic [1:0]         rd_addr_i,
  output logic [NUM_SRC-1:0] rd_data_o,
  input  logic               fifo_en_i,
  input  logic [TRIG_W-1:0]  tx_trig_sel_i,
  input  logic [CNT_W-1:0]   tx_cnt_i,
  input  logic               tx_start_i,
  input  logic               tx_done_i,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] set_vec, clr_vec, src_q, mask_q, pend;
  logic               trig_hit, mask_we, xmit_empty, buf_empty;
  reg_sel_e           wsel, rsel;

  assign wsel = reg_sel_e'(wr_addr_i);
  assign rsel = reg_sel_e'(rd_addr_i);

  uart_tx_trigger #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_trig (
    .fifo_en_i(fifo_en_i),
    .sel_i    (tx_trig_sel_i),
    .cnt_i    (tx_cnt_i),
    .hit_o    (trig_hit)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_RX]    = rx_evt_i;
    set_vec[SRC_ERR]   = err_evt_i;
    set_vec[SRC_TX]    = tx_evt_i | tx_done_i | trig_hit;
    set_vec[SRC_MODEM] = modem_evt_i;
  end

  // both pending and source writes clear the underlying source
  assign clr_vec = (wr_en_i && (wsel == REG_PEND || wsel == REG_SRC)) ? wr_data_i : '0;
  assign mask_we = wr_en_i && (wsel == REG_MASK);

  uart_irq_src_regs u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .mask_we_i(mask_we),
    .mask_d_i (wr_data_i),
    .src_o    (src_q),
    .mask_o   (mask_q)
  );

  uart_tx_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (tx_start_i),
    .done_i      (tx_done_i),
    .xmit_empty_o(xmit_empty),
    .buf_empty_o (buf_empty)
  );

  assign pend  = src_q & ~mask_q;
  assign irq_o = |pend;

  always_comb begin
    case (rsel)
      REG_PEND: rd_data_o = pend;
      REG_SRC:  rd_data_o = src_q;
      REG_MASK: rd_data_o = mask_q;
      default:  rd_data_o = {1'b0, xmit_empty, buf_empty, 1'b0};
    endcase
  end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int unsigned CHANNEL = 1,
  parameter int unsigned CNT_W   = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_evt_i,
  input logic             modem_evt_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_addr_i,
  input logic [3:0]       wr_data_i,
  input logic             fifo_en_i,
  input logic [2:0]       tx_trig_sel_i,
  input logic [CNT_W-1:0] tx_cnt_i,
  input logic             tx_start_i,
  input logic             tx_done_i,
  input logic             irq_o,
  input logic [3:0]       src_q,
  input logic [3:0]       mask_q,
  input logic             xmit_empty,
  input logic             buf_empty
);
  localparam int MULT = (CHANNEL == 0) ? 32 :
                        (CHANNEL == 1 || CHANNEL == 4) ? 8 :
                        (CHANNEL == 2 || CHANNEL == 3) ? 2 : 0;
  int exp_lvl;
  assign exp_lvl = int'(tx_trig_sel_i) * MULT;

  p_rx_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_i |=> src_q[0]);

  p_irq_level_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(src_q & ~mask_q));

  p_pend_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == 2'd0 && wr_data_i[3] && !modem_evt_i |=> !src_q[3]);

  p_src_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == 2'd1 && wr_data_i[0] && !rx_evt_i |=> !src_q[0]);

  p_mask_upd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == 2'd2 |=> mask_q == $past(wr_data_i));

  // threshold scaling per channel (R7)
  p_trig_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_i && (int'(tx_cnt_i) <= exp_lvl) |=> src_q[2]);

  p_stat_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> xmit_empty && buf_empty && src_q[2]);

  p_stat_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i && !tx_done_i |=> !xmit_empty && !buf_empty);

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_evt_i && wr_en_i && wr_addr_i == 2'd1 && wr_data_i[0] |=> src_q[0]);
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.CHANNEL(CHANNEL), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_evt_i     (rx_evt_i),
  .modem_evt_i  (modem_evt_i),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .wr_data_i    (wr_data_i),
  .fifo_en_i    (fifo_en_i),
  .tx_trig_sel_i(tx_trig_sel_i),
  .tx_cnt_i     (tx_cnt_i),
  .tx_start_i   (tx_start_i),
  .tx_done_i    (tx_done_i),
  .irq_o        (irq_o),
  .src_q        (src_q),
  .mask_q       (mask_q),
  .xmit_empty   (xmit_empty),
  .buf_empty    (buf_empty)
);

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  localparam int CH = 1;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_e = 0, er_e = 0, tx_e = 0, md_e = 0;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0, rd_addr = 0;
  logic [3:0] wr_data = 0;
  logic [3:0] rd_data;
  logic fifo_en = 0;
  logic [2:0] trig_sel = 0;
  logic [CW-1:0] tx_cnt = 8'hff;
  logic tx_start = 0, tx_done = 0;
  logic irq;

  int total = 0;
  int bad = 0;
  int m_src = 0, m_mask = 0, m_st = 3;

  always #10 clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(CH), .CNT_W(CW)) u_uart_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_evt_i(rx_e), .err_evt_i(er_e), .tx_evt_i(tx_e), .modem_evt_i(md_e),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .fifo_en_i(fifo_en), .tx_trig_sel_i(trig_sel), .tx_cnt_i(tx_cnt),
    .tx_start_i(tx_start), .tx_done_i(tx_done), .irq_o(irq)
  );

  function automatic int exp_level(int sel);
    int m;
    case (CH)
      0: m = 32;
      1, 4: m = 8;
      2, 3: m = 2;
      default: m = 0;
    endcase
    return sel * m;
  endfunction

  function automatic int exp_read(int a);
    case (a)
      0: return m_src & ~m_mask & 15;
      1: return m_src;
      2: return m_mask;
      default: return m_st << 1;
    endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check("R2", "irq", int'(irq), int'((m_src & ~m_mask & 15) != 0));
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      check(tag, $sformatf("read sel %0d", a), int'(rd_data), exp_read(a));
    end
  endtask

  task automatic step(string tag);
    int set_v, clr_v;
    @(posedge clk);
    set_v = {28'd0, md_e, tx_e, er_e, rx_e};
    if (tx_done) set_v |= 4;
    if (fifo_en && int'(tx_cnt) <= exp_level(int'(trig_sel))) set_v |= 4;
    clr_v = (wr_en && wr_addr <= 1) ? int'(wr_data) : 0;
    m_src = (m_src & ~clr_v & 15) | set_v;
    if (wr_en && wr_addr == 2) m_mask = int'(wr_data);
    if (tx_done) m_st = 3;
    else if (tx_start) m_st = 0;
    @(negedge clk);
    {rx_e, er_e, tx_e, md_e, wr_en, tx_start, tx_done} = '0;
    compare_all(tag);
  endtask

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = 2'(a); wr_data = 4'(d);
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    compare_all("R10");
    check("R8", "status reset", (m_st << 1), 6);

    rx_e = 1; step("R1");
    er_e = 1; step("R1");
    md_e = 1; step("R1");
    tx_e = 1; step("R1");
    wr(2, 4'b0101); step("R5");
    wr(2, 4'b1111); step("R2");
    wr(2, 4'b0000); step("R5");
    wr(0, 4'b1000); step("R3");
    wr(0, 4'b0001); step("R3");
    wr(1, 4'b0110); step("R4");
    rx_e = 1; wr(1, 4'b0001); step("R9");
    md_e = 1; wr(0, 4'b1000); step("R9");
    wr(1, 4'b1111); step("R4");

    fifo_en = 1; trig_sel = 1; tx_cnt = 8'd9; step("R7");
    tx_cnt = 8'd8; step("R7");
    wr(1, 4'b0100); tx_cnt = 8'd20; step("R6");
    trig_sel = 7; tx_cnt = 8'd57; step("R7");
    tx_cnt = 8'd56; step("R7");
    wr(1, 4'b0100); tx_cnt = 8'd60; step("R6");
    trig_sel = 0; tx_cnt = 8'd0; step("R6");
    wr(1, 4'b0100); fifo_en = 0; step("R6");
    wr(1, 4'b0100); step("R6");
    step("R6");

    tx_start = 1; step("R8");
    step("R8");
    tx_done = 1; step("R8");
    wr(1, 4'b0100); tx_start = 1; tx_done = 1; step("R8");
    wr(1, 4'b1111); step("R4");

    for (int i = 0; i < 300; i++) begin
      rx_e = 1'($urandom); er_e = 1'($urandom); tx_e = ($urandom % 4) == 0;
      md_e = 1'($urandom);
      if ($urandom % 2) wr(int'($urandom % 4), int'($urandom % 16));
      fifo_en = 1'($urandom); trig_sel = 3'($urandom); tx_cnt = 8'($urandom % 64);
      tx_start = ($urandom % 4) == 0; tx_done = ($urandom % 5) == 0;
      step("R2");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule